// File: doc/BRIEF.md
# Three-Phase Staircase Gate Sequencer

This block drives the gates of a three-phase, five-level inverter at fundamental frequency. One stack of three H-bridge cells is shared by all three phases through a common junction. Each phase reaches that junction through its own bidirectional switch. A two-level three-phase bridge supplies the extreme levels. A step pulse, issued every 15 electrical degrees by an external angle timebase, advances a ring of 24 states. Each state fixes a pole level from 0 to 4 for each of the three phases.

The block turns the pole levels into 21 gate signals. These are one bidirectional-switch gate per phase, an upper and a lower bridge gate per phase, and four gates per H-bridge cell. The ring is built so that at most one phase is at an intermediate level (1, 2 or 3) at any time. The shared stack therefore only has to produce that one level, and the block reports it on a 2-bit junction output. Switches that take turns within one leg are separated by a programmable dead time counted in clock cycles. Reset and a low enable take every gate off and send the ring back to its first state.

Top module: `tri_stair_seq`

## Requirements
- R1: While reset is asserted, or on the clock edge after enable is sampled low, all 21 gate outputs are 0 and the ring returns to state 0. In state 0, junc_level and overlap_err are 0.
- R2: The ring moves to the next state only on a clock edge where enable and step_tick are both high. After state 23 it wraps to state 0. step_tick pulses while enable is low have no effect.
- R3: The pole levels (A,B,C) for states 0 to 23, in order, are: 044 043 042 041 040 140 240 340 440 430 420 410 400 401 402 403 404 304 204 104 004 014 024 034.
- R4: A phase at level 4 has its upper bridge gate (br_hi) on, and its lower gate and bidirectional gate off. A phase at level 0 has its lower bridge gate (br_lo) on, and its other two gates off. Bit p of bd_gate, br_hi and br_lo belongs to phase p, with A = 0, B = 1 and C = 2.
- R5: A phase at level 1, 2 or 3 has its bidirectional gate on and both of its bridge gates off. At most one bidirectional gate is on at a time.
- R6: cell_gate[4k+3:4k] drives cell k (k = 0, 1, 2). Bit 0 is the upper-left switch, bit 1 lower-left, bit 2 upper-right and bit 3 lower-right. When the junction level is L, cells k < L output positive with pattern 4'b1001. All other cells are bypassed with pattern 4'b1010. No leg ever has both of its switches on.
- R7: junc_level equals the level of the single phase that is at level 1 to 3. It is 0 when no phase is at an intermediate level.
- R8: If a state had more than one phase at an intermediate level, overlap_err would be raised and all bidirectional gates forced off. The ring never produces such a state, so overlap_err stays 0.
- R9: Within a group (one phase's {bd, hi, lo}, or one cell leg), a gate turns on only after every gate of that group has been off for dead_cycles+1 clock cycles. Gates that stay wanted stay on. After a state change, turn-offs take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low forces gates off and rewinds the ring |
| step_tick | input | 1 | Single-cycle pulse that advances the ring by one state |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| bd_gate | output | 3 | Bidirectional switch gate per phase |
| br_hi | output | 3 | Two-level bridge upper gate per phase |
| br_lo | output | 3 | Two-level bridge lower gate per phase |
| cell_gate | output | 12 | H-bridge cell gates, four per cell |
| junc_level | output | 2 | Level the shared stack is producing (0 when none) |
| overlap_err | output | 1 | More than one phase at an intermediate level |

## Verification
The hardest case to reach from the ports is a step pulse that arrives while a dead-time interval from the previous step is still running. In that case a leg is asked to change again before its partner has turned on. The random stimulus therefore mixes step gaps shorter than the dead time with gaps long enough for the outputs to settle, and it compares outputs only after a settled gap. Directed steps measure the exact gap between a bridge gate turning off and the bidirectional gate turning on, and between the two switches of a cell leg, for a zero and a non-zero dead time. The overlap error cannot be reached at all, so it is covered by an always-zero check and by an assertion that the bidirectional gates go off whenever it is raised.

// File: rtl/tri_stair_pkg.sv
package tri_stair_pkg;
  localparam int NPH    = 3;
  localparam int NCELL  = 3;
  localparam int NSTATE = 24;
  localparam int IDX_W  = $clog2(NSTATE);
  localparam int PH_SHIFT = NSTATE / NPH;
  localparam int LVL_TOP  = NCELL + 1;

  typedef logic [2:0] lvl_t;

  // Level of phase A at ring position i: low plateau, rising ramp, high plateau, falling ramp.
  function automatic lvl_t phase_a_level(input int i);
    if (i < 5)       return lvl_t'(0);
    else if (i < 8)  return lvl_t'(i - 4);
    else if (i < 17) return lvl_t'(LVL_TOP);
    else if (i < 20) return lvl_t'(20 - i);
    else             return lvl_t'(0);
  endfunction

  // Phase p reads the phase-A profile offset by p thirds of the ring.
  function automatic lvl_t phase_level(input logic [IDX_W-1:0] idx, input int p);
    int j;
    j = int'(idx) + PH_SHIFT * p;
    if (j >= NSTATE) j = j - NSTATE;
    return phase_a_level(j);
  endfunction

  function automatic logic is_mid(input lvl_t l);
    return (l != 3'd0) && (l != lvl_t'(LVL_TOP));
  endfunction
endpackage

// File: rtl/tss_ring.sv
module tss_ring
  import tri_stair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step_tick,
  output logic [IDX_W-1:0] idx,
  output logic             step_go
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSTATE - 1);

  assign step_go = enable & step_tick;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) idx <= '0;
    else if (step_go)      idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/tss_decode.sv
module tss_decode
  import tri_stair_pkg::*;
(
  input  logic [IDX_W-1:0]   idx,
  output logic [NPH-1:0]     bd_want,
  output logic [NPH-1:0]     hi_want,
  output logic [NPH-1:0]     lo_want,
  output logic [4*NCELL-1:0] cell_want,
  output logic [1:0]         junc,
  output logic               err
);
  lvl_t           lvl [NPH];
  logic [NPH-1:0] mid;
  logic [1:0]     mid_or;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign lvl[p]     = phase_level(idx, p);
    assign mid[p]     = is_mid(lvl[p]);
    assign hi_want[p] = (lvl[p] == lvl_t'(LVL_TOP));
    assign lo_want[p] = (lvl[p] == 3'd0);
    assign bd_want[p] = mid[p] & ~err;
  end

  always_comb begin
    mid_or = '0;
    for (int p = 0; p < NPH; p++)
      if (mid[p]) mid_or = mid_or | lvl[p][1:0];
  end

  assign err  = ($countones(mid) > 1);
  assign junc = err ? 2'd0 : mid_or;

  // Cell k adds its supply when the junction level exceeds k; otherwise it is bypassed.
  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    assign cell_want[4*k +: 4] = (int'(junc) > k) ? 4'b1001 : 4'b1010;
  end
endmodule

// File: rtl/tss_dt_guard.sv
module tss_dt_guard #(
  parameter int W    = 2,
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [DT_W-1:0] dead,
  input  logic [W-1:0]    want,
  output logic [W-1:0]    gate
);
  logic [DT_W-1:0] cnt;
  logic [W-1:0]    off_now;
  logic            allow_on;

  assign off_now  = gate & ~want;
  assign allow_on = (cnt == '0) && (off_now == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate <= '0;
      cnt  <= '0;
    end else if (!enable) begin
      gate <= '0;
      cnt  <= dead;
    end else begin
      gate <= want & (gate | {W{allow_on}});
      if (|off_now)       cnt <= dead;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tri_stair_seq.sv
module tri_stair_seq
  import tri_stair_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            step_tick,
  input  logic [DT_W-1:0] dead_cycles,
  output logic [2:0]      bd_gate,
  output logic [2:0]      br_hi,
  output logic [2:0]      br_lo,
  output logic [11:0]     cell_gate,
  output logic [1:0]      junc_level,
  output logic            overlap_err
);
  logic [IDX_W-1:0]   seq_idx;
  logic               step_go;
  logic [NPH-1:0]     bd_want, hi_want, lo_want;
  logic [4*NCELL-1:0] cell_want;

  tss_ring u_ring (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_tick(step_tick),
    .idx(seq_idx), .step_go(step_go)
  );

  tss_decode u_dec (
    .idx(seq_idx), .bd_want(bd_want), .hi_want(hi_want), .lo_want(lo_want),
    .cell_want(cell_want), .junc(junc_level), .err(overlap_err)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase_leg
    logic [2:0] g;
    tss_dt_guard #(.W(3), .DT_W(DT_W)) u_g (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dead(dead_cycles),
      .want({bd_want[p], hi_want[p], lo_want[p]}), .gate(g)
    );
    assign bd_gate[p] = g[2];
    assign br_hi[p]   = g[1];
    assign br_lo[p]   = g[0];
  end

  // Two legs per cell: leg 2k is bits {1,0} of cell k, leg 2k+1 is bits {3,2}.
  for (genvar g = 0; g < 2*NCELL; g++) begin : g_cell_leg
    tss_dt_guard #(.W(2), .DT_W(DT_W)) u_g (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dead(dead_cycles),
      .want(cell_want[2*g +: 2]), .gate(cell_gate[2*g +: 2])
    );
  end
endmodule

// File: rtl/tri_stair_seq_chk.sv
module tri_stair_seq_chk #(
  parameter int DT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic [DT_W-1:0] dead_cycles,
  input logic [2:0]      bd_gate,
  input logic [2:0]      br_hi,
  input logic [2:0]      br_lo,
  input logic [11:0]     cell_gate,
  input logic            overlap_err,
  input logic            step_go,
  input logic [4:0]      seq_idx
);
  localparam int SW = DT_W + 1;
  localparam logic [SW-1:0] SMAX = '1;

  assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (bd_gate == '0 && br_hi == '0 && br_lo == '0 && cell_gate == '0));

  assert_ring_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |=> seq_idx == (($past(seq_idx) == 5'd23) ? 5'd0 : $past(seq_idx) + 5'd1));

  assert_ring_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step_go) |=> $stable(seq_idx));

  assert_single_bd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bd_gate));

  assert_err_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> bd_gate == '0);

  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic [2:0]    grp, prev;
    logic [SW-1:0] since;
    assign grp = {bd_gate[p], br_hi[p], br_lo[p]};
    always_ff @(posedge clk) begin
      if (!rst_n) begin prev <= '0; since <= SMAX; end
      else begin
        prev <= grp;
        if (|(prev & ~grp))   since <= SW'(1);
        else if (since != SMAX) since <= since + 1'b1;
      end
    end
    assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grp) <= 1);
    assert_phase_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grp & ~prev)) |-> (since > SW'(dead_cycles)));
  end

  for (genvar g = 0; g < 6; g++) begin : g_leg
    logic [1:0]    grp, prev;
    logic [SW-1:0] since;
    assign grp = cell_gate[2*g +: 2];
    always_ff @(posedge clk) begin
      if (!rst_n) begin prev <= '0; since <= SMAX; end
      else begin
        prev <= grp;
        if (|(prev & ~grp))   since <= SW'(1);
        else if (since != SMAX) since <= since + 1'b1;
      end
    end
    assert_leg_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grp != 2'b11);
    assert_leg_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grp & ~prev)) |-> (since > SW'(dead_cycles)));
  end
endmodule

bind tri_stair_seq tri_stair_seq_chk #(.DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .dead_cycles(dead_cycles),
  .bd_gate(bd_gate), .br_hi(br_hi), .br_lo(br_lo), .cell_gate(cell_gate),
  .overlap_err(overlap_err), .step_go(step_go), .seq_idx(seq_idx)
);

// File: tb/sim_tri_stair_seq.sv
module sim_tri_stair_seq;
  localparam int DT_W = 4;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            enable = 0;
  logic            step_tick = 0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic [2:0]      bd_gate, br_hi, br_lo;
  logic [11:0]     cell_gate;
  logic [1:0]      junc_level;
  logic            overlap_err;

  int checks = 0;
  int fails  = 0;
  int model_idx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_stair_seq #(.DT_W(DT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_tick(step_tick),
    .dead_cycles(dead_cycles), .bd_gate(bd_gate), .br_hi(br_hi), .br_lo(br_lo),
    .cell_gate(cell_gate), .junc_level(junc_level), .overlap_err(overlap_err)
  );

  // Sequence written as decimal codes: hundreds = A, tens = B, units = C.
  int seq_code [24] = '{44, 43, 42, 41, 40, 140, 240, 340, 440, 430, 420, 410,
                        400, 401, 402, 403, 404, 304, 204, 104, 4, 14, 24, 34};

  function automatic int digit(input int idx, input int ph);
    int c;
    c = seq_code[idx];
    if (ph == 0) return c / 100;
    if (ph == 1) return (c / 10) % 10;
    return c % 10;
  endfunction

  // Packed as {bd, hi, lo, cells, junc, err}, 24 bits.
  function automatic logic [23:0] expect_vec(input int idx);
    logic [2:0] bd, hi, lo;
    logic [11:0] cl;
    int jl;
    jl = 0;
    for (int p = 0; p < 3; p++) begin
      int l;
      l = digit(idx, p);
      bd[p] = (l >= 1 && l <= 3);
      hi[p] = (l == 4);
      lo[p] = (l == 0);
      if (l >= 1 && l <= 3) jl = l;
    end
    for (int k = 0; k < 3; k++) cl[4*k +: 4] = (k < jl) ? 4'b1001 : 4'b1010;
    return {bd, hi, lo, cl, 2'(jl), 1'b0};
  endfunction

  function automatic logic [23:0] actual_vec();
    return {bd_gate, br_hi, br_lo, cell_gate, junc_level, overlap_err};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    logic [23:0] e, a;
    e = expect_vec(model_idx);
    a = actual_vec();
    check(a == e, req, 32'(a), 32'(e));
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    step_tick = 1;
    @(negedge clk);
    step_tick = 0;
    if (enable) model_idx = (model_idx == 23) ? 0 : model_idx + 1;
  endtask

  // Negedge count from the first sample with 'off' low to the first with 'on' high.
  task automatic measure_gap(input int ph_bit, input bit use_cell, input int exp_gap, input string req);
    int t_off, t_on;
    t_off = -1; t_on = -1;
    tick();
    for (int i = 0; i < 40; i++) begin
      logic off_sig, on_sig;
      off_sig = use_cell ? cell_gate[ph_bit + 1] : br_hi[ph_bit];
      on_sig  = use_cell ? cell_gate[ph_bit]     : bd_gate[ph_bit];
      if (t_off < 0 && !off_sig) t_off = i;
      if (t_on < 0 && on_sig) t_on = i;
      @(negedge clk);
    end
    check(t_off >= 0 && t_on - t_off == exp_gap, req, 32'(t_on - t_off), 32'(exp_gap));
  endtask

  // Every-cycle leg exclusivity monitor.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      bad = 0;
      for (int p = 0; p < 3; p++)
        if (int'(bd_gate[p]) + int'(br_hi[p]) + int'(br_lo[p]) > 1) bad = 1;
      for (int g = 0; g < 6; g++)
        if (cell_gate[2*g +: 2] == 2'b11) bad = 1;
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL R9 leg overlap: actual %0h expected no overlap", actual_vec());
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    wait_cycles(3);
    // R1: reset state
    check(actual_vec() == 24'h0, "R1 reset", 32'(actual_vec()), 0);
    rst_n = 1;
    wait_cycles(2);
    check(actual_vec() == 24'h0, "R1 disabled after reset", 32'(actual_vec()), 0);
    enable = 1;
    wait_cycles(3);
    check_state("R3 R4 R6 R7 state 0");

    // R2: pulses while disabled are ignored
    enable = 0;
    @(negedge clk);
    tick(); tick(); tick();
    enable = 1;
    wait_cycles(3);
    check_state("R2 ignore ticks when disabled");

    // R9: dead time gaps, zero then five cycles
    dead_cycles = 0;
    for (int i = 0; i < 8; i++) begin tick(); wait_cycles(3); end
    check_state("R3 R4 state 8");
    measure_gap(1, 0, 1, "R9 phase B hi->bd gap, dead 0");
    model_idx = 9;
    check_state("R5 R7 state 9");
    enable = 0; @(negedge clk); dead_cycles = 5; @(negedge clk);
    enable = 1; model_idx = 0;
    wait_cycles(10);
    for (int i = 0; i < 8; i++) begin tick(); wait_cycles(8); end
    measure_gap(1, 0, 6, "R9 phase B hi->bd gap, dead 5");
    check_state("R5 R7 state 9 dead 5");
    // cell 1 left leg: state 5 (level 1) -> 6 (level 2), lower-left off, upper-left on
    enable = 0; @(negedge clk); enable = 1; model_idx = 0;
    wait_cycles(10);
    for (int i = 0; i < 5; i++) begin tick(); wait_cycles(8); end
    check_state("R6 state 5 level 1");
    measure_gap(4, 1, 6, "R9 cell 1 leg gap, dead 5");
    check_state("R6 R7 state 6 level 2");

    // R2: full wrap
    for (int i = 0; i < 24; i++) begin
      tick(); wait_cycles(8);
      check_state("R2 R3 R4 R5 R6 R7 R8 ring walk");
    end

    // Random mix of short and settled gaps, occasional disable.
    for (int it = 0; it < 400; it++) begin
      int r, w;
      r = int'($urandom % 100);
      if (r < 6) begin
        enable = 0;
        @(negedge clk);
        dead_cycles = DT_W'($urandom % 8);
        model_idx = 0;
        wait_cycles(2);
        check(actual_vec() == 24'h0, "R1 disable", 32'(actual_vec()), 0);
        enable = 1;
      end else begin
        tick();
        w = 1 + int'($urandom % (int'(dead_cycles) + 6));
        wait_cycles(w);
        if (w >= int'(dead_cycles) + 3) check_state("R3 R4 R5 R6 R7 R9 random");
      end
    end
    wait_cycles(int'(dead_cycles) + 3);
    check_state("R9 final settle");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule